// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Cause Flags

This block merges three internal reset requests and an external active-low reset pin into one synchronous system reset. The internal requests are a comparator request (gated by an enable), a watchdog timeout from an on-board watchdog, and a flash access violation. Once a request is accepted, the system reset is held for a fixed number of clocks and is then released on a clock edge. The external pin is an input only. No internal cause ever drives it.

A cause register shows which source produced the most recent reset. It has one flag per source and exactly one flag is set at a time. The watchdog counts system clock ticks divided by twelve. A kick restarts it, and a disable pulse stops it. Every reset, whatever its cause, turns the watchdog back on and clears its count.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `pin_rst_n` is low, `sys_rst` is 1 and `rst_cause` reads 8'h01 (bit 0 = pin). `sys_rst` falls at the 16th rising clock edge after the pin returns high.
- R2: When `cmp_rst_en` and `cmp_below` are both 1 at a clock edge outside reset, a reset starts, and `rst_cause` reads 8'h20 (bit 5 = comparator).
- R3: With `cmp_rst_en` at 0, `cmp_below` has no effect on `sys_rst`.
- R4: If the running watchdog gets no kick for 12*WD_TICKS (96) clocks, a reset starts and `rst_cause` reads 8'h08 (bit 3 = watchdog).
- R5: A one-clock pulse on `wd_kick` restarts the watchdog count, so kicks spaced less than 96 clocks apart keep `sys_rst` at 0.
- R6: A pulse on `wd_off` stops the watchdog until the next reset, and a later `wd_kick` does not restart it.
- R7: After any reset the watchdog is running from a cleared count. Without kicks it expires 96 clocks after `sys_rst` falls.
- R8: A `flash_err` pulse outside reset starts a reset, and `rst_cause` reads 8'h40 (bit 6 = flash).
- R9: An internal reset holds `sys_rst` at 1 for exactly 16 clocks, starting at the edge that samples the request.
- R10: Exactly one cause flag is set, and the previous flags are cleared. If requests arrive together, flash wins over watchdog and watchdog wins over comparator.
- R11: Requests that arrive while `sys_rst` is 1 are ignored: the reset is not lengthened and `rst_cause` does not change.
- R12: Bits 1, 2, 4 and 7 of `rst_cause` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous assert |
| cmp_below | input | 1 | Comparator result: 1 when the non-inverting input is below the inverting input |
| cmp_rst_en | input | 1 | Enables the comparator as a reset source |
| wd_kick | input | 1 | One-clock watchdog service pulse |
| wd_off | input | 1 | One-clock pulse that stops the watchdog |
| flash_err | input | 1 | Flash access violation request |
| sys_rst | output | 1 | Internal system reset, active high |
| rst_cause | output | 8 | One-hot cause of the most recent reset |

## Verification
Every cycle, the assertions check the following. The cause register stays one-hot with no unused bits set. It stays frozen while reset is asserted. A rise of the reset can only follow an accepted request. The watchdog is running whenever the reset falls. A stopped watchdog stays stopped until a reset.

Some behaviour only the bench scenarios can show. These are the exact length of the reset after a pin release or an internal request, the 96-clock expiry, kick spacing that keeps the system alive, and the priority order when requests coincide. The cycle-accurate reference model covers these on every clock.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int CAUSE_W   = 8;
  localparam int BIT_PIN   = 0;
  localparam int BIT_WDOG  = 3;
  localparam int BIT_CMP   = 5;
  localparam int BIT_FLASH = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_MASK =
    (8'(1) << BIT_PIN) | (8'(1) << BIT_WDOG) | (8'(1) << BIT_CMP) | (8'(1) << BIT_FLASH);

  typedef enum logic [1:0] {SRC_NONE, SRC_CMP, SRC_WDOG, SRC_FLASH} src_e;

  // priority: flash over watchdog over comparator
  function automatic src_e pick_src(logic fl, logic wd, logic cp);
    if (fl)      return SRC_FLASH;
    else if (wd) return SRC_WDOG;
    else if (cp) return SRC_CMP;
    else         return SRC_NONE;
  endfunction

  function automatic logic [CAUSE_W-1:0] src_flag(src_e s);
    logic [CAUSE_W-1:0] f;
    f = '0;
    case (s)
      SRC_FLASH: f[BIT_FLASH] = 1'b1;
      SRC_WDOG:  f[BIT_WDOG]  = 1'b1;
      SRC_CMP:   f[BIT_CMP]   = 1'b1;
      default:   f[BIT_PIN]   = 1'b1;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/rsc_wdog.sv
module rsc_wdog #(
  parameter int DIV   = 12,
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic kick,
  input  logic stop,
  output logic on_o,
  output logic expire_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(DIV - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TICKS - 1);

  logic [PW-1:0] presc_q;
  logic [TW-1:0] tick_q;
  logic          on_q;
  logic          tick_w;
  logic          last_w;

  function automatic logic wd_fires(logic on, logic k, logic s, logic t, logic l);
    return on && !k && !s && t && l;
  endfunction

  assign tick_w   = (presc_q == P_LAST);
  assign last_w   = (tick_q == T_LAST);
  assign expire_o = !sys_rst && wd_fires(on_q, kick, stop, tick_w, last_w);
  assign on_o     = on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b1;
      presc_q <= '0;
      tick_q  <= '0;
    end else if (sys_rst) begin
      on_q    <= 1'b1;
      presc_q <= '0;
      tick_q  <= '0;
    end else if (stop) begin
      on_q    <= 1'b0;
      presc_q <= '0;
      tick_q  <= '0;
    end else if (kick) begin
      presc_q <= '0;
      tick_q  <= '0;
    end else if (on_q) begin
      presc_q <= tick_w ? '0 : presc_q + 1'b1;
      if (tick_w) tick_q <= last_w ? '0 : tick_q + 1'b1;
    end
  end

  // R6: a stopped watchdog only restarts through a reset
  a_r6_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_q && !sys_rst) |=> !on_q);
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= FULL;
    else if (busy_o) cnt_q <= cnt_q - 1'b1;
    else if (start)  cnt_q <= FULL;
  end

  // R9: no early release while more than one hold cycle remains
  a_r9_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CW'(1)) |=> busy_o);
endmodule

// File: rtl/rsc_flags.sv
module rsc_flags
  import rsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  src_e               src,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cause_o <= src_flag(SRC_NONE);
    else if (accept) cause_o <= src_flag(src);
  end
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
  import rsc_pkg::*;
#(
  parameter int HOLD     = 16,
  parameter int WD_DIV   = 12,
  parameter int WD_TICKS = 8
) (
  input  logic       clk,
  input  logic       pin_rst_n,
  input  logic       cmp_below,
  input  logic       cmp_rst_en,
  input  logic       wd_kick,
  input  logic       wd_off,
  input  logic       flash_err,
  output logic       sys_rst,
  output logic [7:0] rst_cause
);
  logic wd_on;
  logic wd_expire;
  logic cmp_req;
  src_e src_w;
  logic accept_w;

  assign cmp_req  = cmp_rst_en && cmp_below;
  assign src_w    = pick_src(flash_err, wd_expire, cmp_req);
  assign accept_w = !sys_rst && (src_w != SRC_NONE);

  rsc_wdog #(.DIV(WD_DIV), .TICKS(WD_TICKS)) i_wdog (
    .clk(clk), .rst_n(pin_rst_n), .sys_rst(sys_rst),
    .kick(wd_kick), .stop(wd_off), .on_o(wd_on), .expire_o(wd_expire)
  );

  rsc_stretch #(.HOLD(HOLD)) i_stretch (
    .clk(clk), .rst_n(pin_rst_n), .start(accept_w), .busy_o(sys_rst)
  );

  rsc_flags i_flags (
    .clk(clk), .rst_n(pin_rst_n), .accept(accept_w), .src(src_w), .cause_o(rst_cause)
  );

  // R10: exactly one cause flag
  a_r10_single_flag: assert property (@(posedge clk) disable iff (!pin_rst_n)
    $countones(rst_cause) == 1);
  // R12: unused bits stay clear
  a_r12_unused_zero: assert property (@(posedge clk) disable iff (!pin_rst_n)
    (rst_cause & ~CAUSE_MASK) == 8'h00);
  // R11: cause frozen while reset is held
  a_r11_frozen: assert property (@(posedge clk) disable iff (!pin_rst_n)
    ($past(sys_rst) && sys_rst) |-> $stable(rst_cause));
  // R9: reset rises only after an accepted request
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!pin_rst_n)
    $rose(sys_rst) |-> $past(accept_w));
  // R7: watchdog running as reset drops
  a_r7_wd_running: assert property (@(posedge clk) disable iff (!pin_rst_n)
    $fell(sys_rst) |-> wd_on);
endmodule

// File: tb/test_rst_source_ctrl.sv
`timescale 1ns/1ps
module test_rst_source_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int DIV  = 12;
  localparam int LIM  = 8;
  localparam int WDN  = DIV * LIM;

  logic clk = 0;
  logic pin_rst_n = 1, cmp_below = 0, cmp_rst_en = 0, wd_kick = 0, wd_off = 0, flash_err = 0;
  logic sys_rst;
  logic [7:0] rst_cause;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  rst_source_ctrl #(.HOLD(HOLD), .WD_DIV(DIV), .WD_TICKS(LIM)) i_rst_source_ctrl (
    .clk(clk), .pin_rst_n(pin_rst_n), .cmp_below(cmp_below), .cmp_rst_en(cmp_rst_en),
    .wd_kick(wd_kick), .wd_off(wd_off), .flash_err(flash_err),
    .sys_rst(sys_rst), .rst_cause(rst_cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_cnt = HOLD, m_el = 0;
  bit m_on = 1, m_rst_now, m_wexp;
  logic [7:0] m_cause = 8'h01;

  always @(posedge clk or negedge pin_rst_n) begin
    if (!pin_rst_n) begin
      m_cnt = HOLD; m_cause = 8'h01; m_on = 1; m_el = 0;
    end else begin
      m_rst_now = (m_cnt != 0);
      if (m_rst_now) begin
        m_cnt = m_cnt - 1; m_on = 1; m_el = 0;
      end else begin
        m_wexp = m_on && !wd_off && !wd_kick && (m_el == WDN - 1);
        if (wd_off) begin m_on = 0; m_el = 0; end
        else if (wd_kick) m_el = 0;
        else if (m_on) m_el = (m_el == WDN - 1) ? 0 : m_el + 1;
        if (flash_err)                      begin m_cause = 8'h40; m_cnt = HOLD; end
        else if (m_wexp)                    begin m_cause = 8'h08; m_cnt = HOLD; end
        else if (cmp_rst_en && cmp_below)   begin m_cause = 8'h20; m_cnt = HOLD; end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(sys_rst === (m_cnt != 0), cur_req, "sys_rst vs model", int'(sys_rst), int'(m_cnt != 0));
    chk(rst_cause === m_cause, cur_req, "rst_cause vs model", int'(rst_cause), int'(m_cause));
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // counts high negedges; clears request inputs after the first
  task automatic measure_high(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (!sys_rst) break;
      n++;
      #1 flash_err = 0; cmp_en_clear();
    end
    #1;
  endtask

  task automatic cmp_en_clear();
    cmp_rst_en = 0; cmp_below = 0; wd_kick = 0; wd_off = 0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (sys_rst) break;
      n++;
      if (n > 5000) break;
    end
    #1;
  endtask

  task automatic wait_low();
    while (sys_rst) @(negedge clk);
    #1;
  endtask

  task automatic pulse_off();
    wd_off = 1; cyc(1); wd_off = 0;
  endtask

  task automatic quiet(int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sys_rst) hi++;
    end
    #1;
  endtask

  initial begin
    int n, hi;
    #2 pin_rst_n = 0;
    #1 cmp_on = 1;
    // R1: pin reset
    cyc(3);
    chk(sys_rst === 1'b1, "R1", "sys_rst during pin", int'(sys_rst), 1);
    chk(rst_cause === 8'h01, "R1", "cause during pin", int'(rst_cause), 8'h01);
    pin_rst_n = 1;
    measure_high(n);
    chk(n == HOLD - 1, "R1", "high negedges after pin release", n, HOLD - 1);

    // R8, R9: flash reset with watchdog stopped first
    cur_req = "R8";
    pulse_off();
    flash_err = 1;
    measure_high(n);
    chk(n == HOLD, "R9", "internal hold length", n, HOLD);
    chk(rst_cause === 8'h40, "R8", "flash cause", int'(rst_cause), 8'h40);

    // R7, R4: watchdog restarted by reset, expires
    cur_req = "R7";
    wait_rise(n);
    chk(n == WDN - 1, "R7", "low negedges to expiry", n, WDN - 1);
    chk(rst_cause === 8'h08, "R4", "watchdog cause", int'(rst_cause), 8'h08);
    wait_low();

    // R5: regular kicks
    cur_req = "R5";
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      int h;
      wd_kick = 1; cyc(1); wd_kick = 0;
      quiet(39, h);
      hi += h;
    end
    chk(hi == 0, "R5", "reset seen while kicked", hi, 0);

    // R6: stop, kick does not restart
    cur_req = "R6";
    pulse_off();
    quiet(300, hi);
    chk(hi == 0, "R6", "reset seen while stopped", hi, 0);
    wd_kick = 1; cyc(1); wd_kick = 0;
    quiet(200, hi);
    chk(hi == 0, "R6", "reset seen after kick on stopped wd", hi, 0);

    // R3: comparator gated off
    cur_req = "R3";
    cmp_below = 1;
    quiet(30, hi);
    chk(hi == 0, "R3", "reset with comparator disabled", hi, 0);
    // R2: comparator enabled
    cur_req = "R2";
    cmp_rst_en = 1;
    measure_high(n);
    chk(n == HOLD, "R2", "comparator hold length", n, HOLD);
    chk(rst_cause === 8'h20, "R2", "comparator cause", int'(rst_cause), 8'h20);

    // R10: simultaneous flash and comparator
    cur_req = "R10";
    pulse_off();
    flash_err = 1; cmp_below = 1; cmp_rst_en = 1;
    measure_high(n);
    chk(rst_cause === 8'h40, "R10", "priority flash over comparator", int'(rst_cause), 8'h40);
    chk(n == HOLD, "R10", "hold length", n, HOLD);

    // R11: requests during reset ignored
    cur_req = "R11";
    cmp_below = 1; cmp_rst_en = 1;
    cyc(1);
    cmp_below = 0; cmp_rst_en = 0;
    n = 1;
    flash_err = 1;
    forever begin
      @(negedge clk);
      if (!sys_rst) break;
      n++;
      #1 flash_err = (n < 10);
    end
    #1 flash_err = 0;
    chk(n == HOLD, "R11", "hold not lengthened", n, HOLD);
    chk(rst_cause === 8'h20, "R11", "cause unchanged", int'(rst_cause), 8'h20);

    // R12 and R1 again: pin reset while running
    cur_req = "R12";
    chk((rst_cause & 8'h96) == 8'h00, "R12", "unused bits", int'(rst_cause & 8'h96), 0);
    cyc(20);
    pin_rst_n = 0;
    cyc(2);
    chk(rst_cause === 8'h01, "R1", "pin cause after internal reset", int'(rst_cause), 8'h01);
    pin_rst_n = 1;
    measure_high(n);
    chk(n == HOLD - 1, "R1", "second pin release", n, HOLD - 1);
    cyc(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule